// File: doc/BRIEF.md
# Max Pooling Unit with Argmax Gradient Routing

This block performs non-overlapping K×K max pooling over a single-channel W×H map of signed fixed-point values held in an internal RAM. A forward run scans every complete window, stores the window maximum in a pooled table and stores the flat input address of the winning element in a location table. A backward run zero-fills a full-size W×H gradient map and then writes each pooled gradient value to the input position recorded for its window. All other positions are left at zero.

Elements are addressed as `x*H + y`, with x in 0..W-1 and y in 0..H-1. The pooled map has PW = floor(W/K) by PH = floor(H/K) entries. Window (i, j) covers x in i*K..i*K+K-1 and y in j*K..j*K+K-1, and its result sits at pooled index `i*PH + j`. Software-side logic loads the input map and the pooled gradients through write ports. It pulses `start` with `mode` selecting the run (0 forward, 1 backward) and reads the results through combinational read ports once `done` has pulsed.

Top module: `maxpool_argmax_unit`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: After a forward run, pooled index i*PH+j holds the signed maximum of window (i, j), and its location entry holds the flat address x*H+y of that maximum.
- R3: Comparison is signed over the full data range: values below -999 are handled, and a window whose elements all equal the most negative value yields that value with the location of the first scanned element.
- R4: Scanning goes through x in ascending order, and for each x through y in ascending order. An element replaces the running maximum only when strictly greater, so among equal maxima the first scanned one wins.
- R5: A backward run first writes zero to all W*H gradient entries, one entry per cycle, before any scatter write. Values left by an earlier backward run therefore do not survive.
- R6: After the clear, the backward run writes pooled gradient p to the gradient entry at location entry p, for every p. All positions without a winner read zero.
- R7: `busy` rises in the cycle after `start` is accepted and stays high until the run ends. `done` is then high for exactly one cycle, with `busy` low.
- R8: A forward run keeps `busy` high for PW*PH*K*K cycles. A backward run keeps it high for W*H + PW*PH cycles.
- R9: A `start` pulse while `busy` is high is ignored: the run length, the single `done` pulse and the results are unchanged.
- R10: When W or H is not a multiple of K, the trailing columns or rows never affect the pooled or location tables, and they receive zero gradient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a run when idle |
| mode | input | 1 | Run select at start: 0 forward, 1 backward |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at end of a run |
| in_we | input | 1 | Input map write enable |
| in_addr | input | AW | Input map write address (x*H+y) |
| in_data | input | DW | Input map write data (signed) |
| pg_we | input | 1 | Pooled gradient write enable |
| pg_addr | input | PAW | Pooled gradient write index |
| pg_data | input | DW | Pooled gradient write data |
| prd_addr | input | PAW | Pooled / location table read index |
| pool_q | output | DW | Pooled maximum at `prd_addr` |
| loc_q | output | AW | Winning flat address at `prd_addr` |
| grd_addr | input | AW | Gradient map read address |
| grad_q | output | DW | Gradient map value at `grd_addr` |

## Verification
On every cycle, the assertions check the following:
- the one-cycle `done` pulse and its link to the end of `busy`;
- that a written location always falls inside the window being pooled, and inside the trimmed region;
- that scatter begins only once the final clear entry has been written;
- that a start raised mid-run does not end the run.

Only the bench scenarios can show the actual values. These are the maxima and tie winners against a reference scan, the handling of the most negative value, the exact busy length per mode, and the full gradient map contents after back-to-back backward runs with moved winners.

// File: rtl/maxpool_argmax_unit.sv
module maxpool_argmax_unit #(
  parameter int DW = 16,
  parameter int W  = 7,
  parameter int H  = 8,
  parameter int K  = 2,
  localparam int PW  = W / K,
  localparam int PH  = H / K,
  localparam int NP  = PW * PH,
  localparam int NE  = W * H,
  localparam int AW  = (NE > 1) ? $clog2(NE) : 1,
  localparam int PAW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 mode,
  output logic                 busy,
  output logic                 done,
  input  logic                 in_we,
  input  logic [AW-1:0]        in_addr,
  input  logic signed [DW-1:0] in_data,
  input  logic                 pg_we,
  input  logic [PAW-1:0]       pg_addr,
  input  logic signed [DW-1:0] pg_data,
  input  logic [PAW-1:0]       prd_addr,
  output logic signed [DW-1:0] pool_q,
  output logic [AW-1:0]        loc_q,
  input  logic [AW-1:0]        grd_addr,
  output logic signed [DW-1:0] grad_q
);

  typedef enum logic [1:0] {S_IDLE, S_FWD, S_CLR, S_SCT} state_t;

  state_t state;
  logic signed [DW-1:0] in_mem   [NE];
  logic signed [DW-1:0] grad_mem [NE];
  logic signed [DW-1:0] pool_mem [NP];
  logic signed [DW-1:0] pg_mem   [NP];
  logic [AW-1:0]        loc_mem  [NP];

  int oi, oj, ki, kj, cidx, pidx;
  logic signed [DW-1:0] run_max;
  logic [AW-1:0]        run_loc;

  int faddr, widx;
  logic signed [DW-1:0] cand, new_max;
  logic [AW-1:0] new_loc, sct_addr;
  logic first_el, last_el, take, fwd_wr, clr_phase, sct_phase;

  assign faddr     = (oi * K + ki) * H + (oj * K + kj);
  assign widx      = oi * PH + oj;
  assign cand      = in_mem[faddr];
  assign first_el  = (ki == 0) && (kj == 0);
  assign last_el   = (ki == K - 1) && (kj == K - 1);
  assign take      = first_el || (cand > run_max);
  assign new_max   = take ? cand : run_max;
  assign new_loc   = take ? AW'(faddr) : run_loc;
  assign fwd_wr    = (state == S_FWD) && last_el;
  assign clr_phase = (state == S_CLR);
  assign sct_phase = (state == S_SCT);
  assign sct_addr  = loc_mem[pidx];
  assign busy      = (state != S_IDLE);

  assign pool_q = pool_mem[prd_addr];
  assign loc_q  = loc_mem[prd_addr];
  assign grad_q = grad_mem[grd_addr];

  always_ff @(posedge clk) begin
    if (in_we) in_mem[in_addr] <= in_data;
    if (pg_we) pg_mem[pg_addr] <= pg_data;
    if (fwd_wr) begin
      pool_mem[widx] <= new_max;
      loc_mem[widx]  <= new_loc;
    end
    if (clr_phase) grad_mem[cidx] <= '0;
    else if (sct_phase) grad_mem[sct_addr] <= pg_mem[pidx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      done    <= 1'b0;
      oi      <= 0;
      oj      <= 0;
      ki      <= 0;
      kj      <= 0;
      cidx    <= 0;
      pidx    <= 0;
      run_max <= '0;
      run_loc <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= mode ? S_CLR : S_FWD;
          oi <= 0; oj <= 0; ki <= 0; kj <= 0;
          cidx <= 0; pidx <= 0;
        end
        S_FWD: begin
          run_max <= new_max;
          run_loc <= new_loc;
          if (kj != K - 1) kj <= kj + 1;
          else begin
            kj <= 0;
            if (ki != K - 1) ki <= ki + 1;
            else begin
              ki <= 0;
              if (oj != PH - 1) oj <= oj + 1;
              else begin
                oj <= 0;
                if (oi != PW - 1) oi <= oi + 1;
                else begin
                  oi    <= 0;
                  state <= S_IDLE;
                  done  <= 1'b1;
                end
              end
            end
          end
        end
        S_CLR: begin
          if (cidx != NE - 1) cidx <= cidx + 1;
          else state <= S_SCT;
        end
        S_SCT: begin
          if (pidx != NP - 1) pidx <= pidx + 1;
          else begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/maxpool_argmax_chk.sv
module maxpool_argmax_chk #(
  parameter int W  = 7,
  parameter int H  = 8,
  parameter int K  = 2,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          fwd_wr,
  input logic [AW-1:0] new_loc,
  input int            oi,
  input int            oj,
  input logic          clr_phase,
  input int            cidx,
  input logic          sct_phase,
  input logic [AW-1:0] sct_addr
);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_loc_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_wr |-> ((int'(new_loc) / H) / K == oi && (int'(new_loc) % H) / K == oj));

  p_scatter_trimmed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sct_phase |-> (int'(sct_addr) / H < (W / K) * K && int'(sct_addr) % H < (H / K) * K));

  p_clear_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sct_phase) |-> ($past(clr_phase) && $past(cidx) == W * H - 1));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy || done));

endmodule

bind maxpool_argmax_unit maxpool_argmax_chk #(.W(W), .H(H), .K(K), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fwd_wr(fwd_wr), .new_loc(new_loc), .oi(oi), .oj(oj),
  .clr_phase(clr_phase), .cidx(cidx), .sct_phase(sct_phase), .sct_addr(sct_addr)
);

// File: tb/maxpool_argmax_unit_tb.sv
`timescale 1ns/1ps
module maxpool_argmax_unit_tb;
  localparam int DW = 16, W = 7, H = 8, K = 2;
  localparam int PW = W / K, PH = H / K, NP = PW * PH, NE = W * H;
  localparam int AW = 6, PAW = 4;

  logic clk = 0, rst_n = 0, start = 0, mode = 0;
  logic busy, done;
  logic in_we = 0, pg_we = 0;
  logic [AW-1:0] in_addr = '0, grd_addr = '0;
  logic [PAW-1:0] pg_addr = '0, prd_addr = '0;
  logic signed [DW-1:0] in_data = '0, pg_data = '0, pool_q, grad_q;
  logic [AW-1:0] loc_q;

  int tests = 0, fails = 0, seed = 7;
  bit finished = 0;
  int img [NE];
  int pg [NP];
  int exp_max [NP];
  int exp_loc [NP];

  always #2.5 clk = ~clk;

  maxpool_argmax_unit #(.DW(DW), .W(W), .H(H), .K(K)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy), .done(done),
    .in_we(in_we), .in_addr(in_addr), .in_data(in_data),
    .pg_we(pg_we), .pg_addr(pg_addr), .pg_data(pg_data),
    .prd_addr(prd_addr), .pool_q(pool_q), .loc_q(loc_q),
    .grd_addr(grd_addr), .grad_q(grad_q));

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return int'($signed(seed[23:8]));
  endfunction

  task automatic load_img();
    for (int a = 0; a < NE; a++) begin
      @(negedge clk);
      in_we = 1; in_addr = AW'(a); in_data = DW'(img[a]);
    end
    @(negedge clk); in_we = 0;
  endtask

  task automatic load_pg();
    for (int p = 0; p < NP; p++) begin
      @(negedge clk);
      pg_we = 1; pg_addr = PAW'(p); pg_data = DW'(pg[p]);
    end
    @(negedge clk); pg_we = 0;
  endtask

  task automatic run(input bit m, input bit poke, input string tag);
    int len;
    int bad;
    len = m ? NE + NP : NP * K * K;
    bad = 0;
    @(negedge clk); start = 1; mode = m;
    @(negedge clk); start = 0;
    for (int n = 1; n <= len; n++) begin
      if (poke && n == 3) begin start = 1; mode = !m; end
      else start = 0;
      if (!(busy === 1'b1 && done === 1'b0)) bad++;
      check(busy === 1'b1 && done === 1'b0, {tag, " R7 busy per cycle"}, busy, 1);
      @(negedge clk);
    end
    start = 0;
    check(busy === 1'b0 && done === 1'b1, {tag, " R8 run length / done"}, done, 1);
    @(negedge clk);
    check(done === 1'b0, {tag, " R7 done single pulse"}, done, 0);
    check(bad == 0, {tag, " R8 busy cycles"}, bad, 0);
  endtask

  task automatic model_fwd();
    for (int i = 0; i < PW; i++)
      for (int j = 0; j < PH; j++) begin
        int bm, bl;
        bm = 0; bl = -1;
        for (int x = i * K; x < i * K + K; x++)
          for (int y = j * K; y < j * K + K; y++)
            if (bl < 0 || img[x * H + y] > bm) begin bm = img[x * H + y]; bl = x * H + y; end
        exp_max[i * PH + j] = bm;
        exp_loc[i * PH + j] = bl;
      end
  endtask

  task automatic check_pool(input string tag);
    for (int p = 0; p < NP; p++) begin
      @(negedge clk); prd_addr = PAW'(p); #1;
      check(int'(pool_q) == exp_max[p], {tag, " max"}, int'(pool_q), exp_max[p]);
      check(int'(loc_q) == exp_loc[p], {tag, " loc"}, int'(loc_q), exp_loc[p]);
    end
  endtask

  task automatic check_grad(input string tag);
    for (int a = 0; a < NE; a++) begin
      int e;
      e = 0;
      for (int p = 0; p < NP; p++) if (exp_loc[p] == a) e = pg[p];
      @(negedge clk); grd_addr = AW'(a); #1;
      check(int'(grad_q) == e, {tag, " R5 R6 R10 grad"}, int'(grad_q), e);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1;
    check(busy === 1'b0 && done === 1'b0, "R1 reset state", busy, 0);
    #11 rst_n = 1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 after release", done, 0);

    // R2 R10: pseudo-random map, trailing column x=6 full of large values
    for (int a = 0; a < NE; a++) img[a] = (a / H >= PW * K) ? 32767 : rnd();
    load_img(); model_fwd();
    run(0, 0, "R2 random fwd");
    check_pool("R2 R10 random");

    // R4: ties everywhere, later duplicates of max
    for (int a = 0; a < NE; a++) img[a] = ((a % H) % K == 1) ? 50 : 50 - (a % 3);
    load_img(); model_fwd();
    run(0, 1, "R4 R9 ties");
    check_pool("R4 R9 ties");

    // R3: all most-negative, and values well below -999
    for (int a = 0; a < NE; a++) img[a] = -32768;
    for (int a = 0; a < NE; a += 5) img[a] = -30000 - a;
    img[1] = -32768;
    load_img(); model_fwd();
    run(0, 0, "R3 negatives");
    check_pool("R3 negatives");

    // R5 R6: backward twice with moved winners
    for (int a = 0; a < NE; a++) img[a] = rnd();
    load_img(); model_fwd();
    run(0, 0, "R2 fwd A");
    check_pool("R2 fwd A");
    for (int p = 0; p < NP; p++) pg[p] = 100 + p;
    load_pg();
    run(1, 0, "R6 bwd A");
    check_grad("bwd A");
    for (int a = 0; a < NE; a++) img[a] = -rnd();
    load_img(); model_fwd();
    run(0, 0, "R2 fwd B");
    for (int p = 0; p < NP; p++) pg[p] = -7 * (p + 1);
    load_pg();
    run(1, 1, "R5 R9 bwd B");
    check_grad("bwd B");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule